// File: doc/BRIEF.md
# Low-Voltage Detector Action Controller

This block is the digital side of a programmable supply monitor. Three comparators report whether the supply sits above a low, a middle and a high threshold. A fourth comparator flags an imminent power loss. Each comparator level is first passed through a synchronizer and an agreement filter. The block then selects one threshold from its configuration and decides whether a dip below that threshold raises a reset request or an interrupt. A status output shows whether the supply is currently above the selected threshold.

Two write ports load the configuration. The option register holds the power-loss reset enable, the action mode and the threshold code used in reset mode. The control register holds the threshold code used in interrupt mode, and it also clears the sticky interrupt flag. The decision logic is a Moore machine with these states:

- OFF: detection disabled.
- ABOVE: armed, with the supply above the threshold.
- BELOW_RST: reset requested.
- FIRE: the one-cycle interrupt.
- BELOW_IRQ: supply low, interrupt already raised.

Its transitions are:

- enable: OFF to ABOVE, BELOW_RST or BELOW_IRQ.
- trip-reset: ABOVE to BELOW_RST.
- trip-irq: ABOVE to FIRE.
- settle: FIRE to BELOW_IRQ.
- recover: any active state to ABOVE.
- mode-swap: BELOW_RST and BELOW_IRQ to each other, with no pulse.
- disable: any state to OFF when the selected code is 00.

Top module: `lvd_action_ctrl`

## Requirements
- R1: Option register bit 2 selects the action: 0 gives a reset request on `lvd_rst_req`, 1 gives an interrupt on `irq_pulse`. The two outputs are never high in the same cycle.
- R2: A 2-bit threshold code maps 01 to the low comparator, 10 to the middle comparator and 11 to the high comparator. In reset mode the code is taken from option register bits 1:0.
- R3: In interrupt mode the code is taken from control register bits 1:0, and option register bits 1:0 have no effect.
- R4: `supply_ok` is 1 when the filtered comparator of the selected threshold shows the supply above that threshold, and 0 when it shows the supply below.
- R5: When the selected code is 00, `supply_ok` reads 1 and neither a reset request nor an interrupt is produced.
- R6: In reset mode `lvd_rst_req` stays high for as long as the filtered input shows the supply below the threshold. It drops once the supply is back above.
- R7: In interrupt mode `irq_pulse` is high for exactly one cycle on each falling crossing. Staying below the threshold gives no further pulses.
- R8: `irq_flag` is set by `irq_pulse`. It is cleared by a control write with bit 7 = 1. A control write with bit 7 = 0 leaves it set.
- R9: `pdn_rst_req` follows the filtered power-loss comparator only while option register bit 7 is 1. When bit 7 is 0, `pdn_rst_req` stays 0.
- R10: After reset all configuration bits are 0. Detection and power-loss reset are therefore both off, `supply_ok` is 1 and no request is active.
- R11: A comparator change that lasts fewer than 4 synchronized cycles has no effect. A change held for 4 or more cycles is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_lo | input | 1 | 1 = supply above the low threshold |
| cmp_mid | input | 1 | 1 = supply above the middle threshold |
| cmp_hi | input | 1 | 1 = supply above the high threshold |
| cmp_pdn | input | 1 | 1 = power loss detected |
| opt_we | input | 1 | Option register write strobe |
| opt_wdata | input | 8 | Option data: bit 7 power-loss enable, bit 2 mode, bits 1:0 reset-mode code |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control data: bits 1:0 interrupt-mode code, bit 7 clears the flag |
| lvd_rst_req | output | 1 | Reset request from the low-voltage path |
| irq_pulse | output | 1 | One-cycle interrupt on a falling crossing |
| irq_flag | output | 1 | Sticky interrupt flag |
| pdn_rst_req | output | 1 | Gated power-loss reset request |
| supply_ok | output | 1 | Status: supply above the selected threshold |

## Verification
The bench picks thresholds whose comparator is the only one low. A design that decoded the code wrongly, or read the code field belonging to the other mode, would then fail to react or would react to the wrong comparator. It holds the supply below the threshold for many cycles after an interrupt-mode crossing. A level-triggered design would produce repeated pulses, and a reset-mode design that only pulsed would drop its request early. It sends 3-cycle comparator glitches, which a filter that is too short would accept, and 4-cycle dips, which a filter that is too long would miss. Finally it clears the flag with bit 7 both low and high, and drives the power-loss input while the enable bit is 0.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_ABOVE,
        ST_BELOW_RST,
        ST_FIRE,
        ST_BELOW_IRQ
    } lvd_state_t;

    localparam int CODE_W   = 2;
    localparam int REG_W    = 8;
    localparam int BIT_PDN  = 7;
    localparam int BIT_MODE = 2;
    localparam int BIT_CLR  = 7;
endpackage

// File: rtl/lvd_sync_filt.sv
module lvd_sync_filt #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4,
    parameter bit RST_VAL     = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          agree_cnt;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    // synchronizer chain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {SYNC_STAGES{RST_VAL}};
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], din};
        end
    end

    // output moves only after FILT_LEN consecutive disagreeing samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout      <= RST_VAL;
            agree_cnt <= '0;
        end else if (synced == dout) begin
            agree_cnt <= '0;
        end else if (agree_cnt == CW'(FILT_LEN - 1)) begin
            dout      <= synced;
            agree_cnt <= '0;
        end else begin
            agree_cnt <= agree_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lvd_cfg_regs.sv
module lvd_cfg_regs
    import lvd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opt_we,
    input  logic [REG_W-1:0]  opt_wdata,
    input  logic              ctl_we,
    input  logic [REG_W-1:0]  ctl_wdata,
    input  logic              irq_set,
    output logic              pdn_en,
    output logic              mode_irq,
    output logic [CODE_W-1:0] rst_code,
    output logic [CODE_W-1:0] irq_code,
    output logic              irq_flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pdn_en   <= 1'b0;
            mode_irq <= 1'b0;
            rst_code <= '0;
        end else if (opt_we) begin
            pdn_en   <= opt_wdata[BIT_PDN];
            mode_irq <= opt_wdata[BIT_MODE];
            rst_code <= opt_wdata[CODE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_code <= '0;
        end else if (ctl_we) begin
            irq_code <= ctl_wdata[CODE_W-1:0];
        end
    end

    // sticky flag: a new event wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_flag <= 1'b0;
        end else if (irq_set) begin
            irq_flag <= 1'b1;
        end else if (ctl_we && ctl_wdata[BIT_CLR]) begin
            irq_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/lvd_fsm.sv
module lvd_fsm
    import lvd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_on,
    input  logic above,
    input  logic mode_irq,
    output logic lvd_rst_req,
    output logic irq_pulse
);
    lvd_state_t state_q, state_d;
    lvd_state_t low_state;

    assign low_state = mode_irq ? ST_BELOW_IRQ : ST_BELOW_RST;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (lvl_on) begin
                    state_d = above ? ST_ABOVE : low_state;
                end
            end
            ST_ABOVE: begin
                if (!lvl_on) begin
                    state_d = ST_OFF;
                end else if (!above) begin
                    state_d = mode_irq ? ST_FIRE : ST_BELOW_RST;
                end
            end
            ST_BELOW_RST, ST_FIRE, ST_BELOW_IRQ: begin
                if (!lvl_on) begin
                    state_d = ST_OFF;
                end else if (above) begin
                    state_d = ST_ABOVE;
                end else begin
                    state_d = low_state;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        lvd_rst_req = 1'b0;
        irq_pulse   = 1'b0;
        unique case (state_q)
            ST_BELOW_RST: lvd_rst_req = 1'b1;
            ST_FIRE:      irq_pulse   = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/lvd_action_ctrl.sv
module lvd_action_ctrl
    import lvd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_lo,
    input  logic             cmp_mid,
    input  logic             cmp_hi,
    input  logic             cmp_pdn,
    input  logic             opt_we,
    input  logic [REG_W-1:0] opt_wdata,
    input  logic             ctl_we,
    input  logic [REG_W-1:0] ctl_wdata,
    output logic             lvd_rst_req,
    output logic             irq_pulse,
    output logic             irq_flag,
    output logic             pdn_rst_req,
    output logic             supply_ok
);
    localparam int NUM_LVL = 3;

    logic [NUM_LVL-1:0] cmp_raw;
    logic [NUM_LVL-1:0] cmp_filt;
    logic               pdn_filt;
    logic               pdn_en;
    logic               mode_irq;
    logic [CODE_W-1:0]  rst_code;
    logic [CODE_W-1:0]  irq_code;
    logic [CODE_W-1:0]  sel_code;
    logic               lvl_on;
    logic               above;

    assign cmp_raw = {cmp_hi, cmp_mid, cmp_lo};

    for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
        lvd_sync_filt #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN),
            .RST_VAL    (1'b1)
        ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (cmp_raw[i]),
            .dout (cmp_filt[i])
        );
    end

    lvd_sync_filt #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN),
        .RST_VAL    (1'b0)
    ) u_pdn_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cmp_pdn),
        .dout (pdn_filt)
    );

    lvd_cfg_regs u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .opt_we   (opt_we),
        .opt_wdata(opt_wdata),
        .ctl_we   (ctl_we),
        .ctl_wdata(ctl_wdata),
        .irq_set  (irq_pulse),
        .pdn_en   (pdn_en),
        .mode_irq (mode_irq),
        .rst_code (rst_code),
        .irq_code (irq_code),
        .irq_flag (irq_flag)
    );

    // threshold source depends on the action mode
    assign sel_code = mode_irq ? irq_code : rst_code;
    assign lvl_on   = (sel_code != '0);

    always_comb begin
        unique case (sel_code)
            2'b01:   above = cmp_filt[0];
            2'b10:   above = cmp_filt[1];
            2'b11:   above = cmp_filt[2];
            default: above = 1'b1;
        endcase
    end

    assign supply_ok   = above;
    assign pdn_rst_req = pdn_en & pdn_filt;

    lvd_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_on     (lvl_on),
        .above      (above),
        .mode_irq   (mode_irq),
        .lvd_rst_req(lvd_rst_req),
        .irq_pulse  (irq_pulse)
    );
endmodule

// File: rtl/lvd_action_chk.sv
module lvd_action_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lvd_rst_req,
    input logic       irq_pulse,
    input logic       irq_flag,
    input logic       pdn_rst_req,
    input logic       pdn_en,
    input logic [1:0] sel_code
);
    // R1
    excl_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lvd_rst_req && irq_pulse));

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> irq_flag);

    // R9
    pdn_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pdn_en |-> !pdn_rst_req);

    // R5
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code == 2'b00 && $past(sel_code) == 2'b00) |-> (!lvd_rst_req && !irq_pulse));
endmodule

bind lvd_action_ctrl lvd_action_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvd_rst_req(lvd_rst_req),
    .irq_pulse  (irq_pulse),
    .irq_flag   (irq_flag),
    .pdn_rst_req(pdn_rst_req),
    .pdn_en     (pdn_en),
    .sel_code   (sel_code)
);

// File: tb/sim_lvd_action_ctrl.sv
`timescale 1ns/1ps
module sim_lvd_action_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_lo = 1'b1, cmp_mid = 1'b1, cmp_hi = 1'b1, cmp_pdn = 1'b0;
    logic       opt_we = 1'b0, ctl_we = 1'b0;
    logic [7:0] opt_wdata = '0, ctl_wdata = '0;
    logic       lvd_rst_req, irq_pulse, irq_flag, pdn_rst_req, supply_ok;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    lvd_action_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .cmp_lo(cmp_lo), .cmp_mid(cmp_mid), .cmp_hi(cmp_hi), .cmp_pdn(cmp_pdn),
        .opt_we(opt_we), .opt_wdata(opt_wdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .lvd_rst_req(lvd_rst_req), .irq_pulse(irq_pulse), .irq_flag(irq_flag),
        .pdn_rst_req(pdn_rst_req), .supply_ok(supply_ok)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_opt(input logic [7:0] d);
        @(negedge clk); opt_we = 1'b1; opt_wdata = d;
        @(negedge clk); opt_we = 1'b0;
    endtask

    task automatic wr_ctl(input logic [7:0] d);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic all_high();
        cmp_lo = 1'b1; cmp_mid = 1'b1; cmp_hi = 1'b1; cmp_pdn = 1'b0;
        cyc(15);
    endtask

    task automatic t_reset();
        cyc(3);
        chk("R10 rst_req", lvd_rst_req, 0);
        chk("R10 irq_flag", irq_flag, 0);
        chk("R10 supply_ok", supply_ok, 1);
        cmp_pdn = 1'b1;
        cyc(15);
        chk("R10 pdn off after reset", pdn_rst_req, 0);
        cmp_pdn = 1'b0;
        cyc(15);
    endtask

    task automatic t_level_off();
        int hits = 0;
        cmp_lo = 1'b0; cmp_mid = 1'b0; cmp_hi = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (lvd_rst_req || irq_pulse) hits++;
        end
        chk("R5 supply_ok with code 00", supply_ok, 1);
        chk("R5 no request with code 00", hits, 0);
        all_high();
    endtask

    task automatic t_reset_mode();
        wr_opt(8'h02);
        cmp_mid = 1'b0;
        cyc(15);
        chk("R2 mid code asserts reset", lvd_rst_req, 1);
        chk("R4 status low below", supply_ok, 0);
        cyc(40);
        chk("R6 reset held while below", lvd_rst_req, 1);
        chk("R1 no irq in reset mode", irq_flag, 0);
        cmp_mid = 1'b1; cmp_lo = 1'b0;
        cyc(15);
        chk("R2 low comparator ignored for code 10", lvd_rst_req, 0);
        chk("R4 status high above", supply_ok, 1);
        all_high();
        wr_ctl(8'h03);
        wr_opt(8'h01);
        cmp_hi = 1'b0; cmp_mid = 1'b0;
        cyc(15);
        chk("R3 interrupt code ignored in reset mode", lvd_rst_req, 0);
        all_high();
        wr_ctl(8'h00);
    endtask

    task automatic t_irq_mode();
        int pulses = 0;
        int rsts = 0;
        wr_ctl(8'h01);
        wr_opt(8'h04);
        cyc(5);
        cmp_lo = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (irq_pulse) pulses++;
            if (lvd_rst_req) rsts++;
        end
        chk("R7 exactly one pulse per crossing", pulses, 1);
        chk("R1 no reset in interrupt mode", rsts, 0);
        chk("R8 flag set", irq_flag, 1);
        wr_ctl(8'h01);
        chk("R8 write bit7=0 keeps flag", irq_flag, 1);
        wr_ctl(8'h81);
        chk("R8 write bit7=1 clears flag", irq_flag, 0);
        all_high();
        wr_opt(8'h07);
        cmp_hi = 1'b0;
        pulses = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (irq_pulse) pulses++;
        end
        chk("R3 option code ignored in interrupt mode", pulses, 0);
        all_high();
        wr_opt(8'h00);
        wr_ctl(8'h80);
    endtask

    task automatic t_filter();
        int hits = 0;
        wr_opt(8'h01);
        cyc(3);
        cmp_lo = 1'b0;
        cyc(3);
        cmp_lo = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (lvd_rst_req) hits++;
        end
        chk("R11 3-cycle glitch ignored", hits, 0);
        cmp_lo = 1'b0;
        cyc(4);
        cmp_lo = 1'b1;
        hits = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (lvd_rst_req) hits++;
        end
        chk("R11 4-cycle dip accepted", (hits > 0) ? 1 : 0, 1);
        all_high();
        wr_opt(8'h00);
    endtask

    task automatic t_pdn();
        cmp_pdn = 1'b1;
        cyc(15);
        chk("R9 gated off", pdn_rst_req, 0);
        wr_opt(8'h80);
        cyc(2);
        chk("R9 enabled follows comparator", pdn_rst_req, 1);
        cmp_pdn = 1'b0;
        cyc(15);
        chk("R9 released", pdn_rst_req, 0);
        wr_opt(8'h00);
    endtask

    initial begin
        cyc(4);
        rst_n = 1'b1;
        t_reset();
        t_level_off();
        t_reset_mode();
        t_irq_mode();
        t_filter();
        t_pdn();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule